// File: doc/BRIEF.md
# Calibrated 1024 Hz Tick Divider

This block turns a slow, imprecise oscillator of roughly 10 kHz into a tick of about 1024 Hz. Each oscillator edge reaches the block as a one-cycle strobe, `src_tick`, already synchronised to the system clock. A phase accumulator adds 2048 for every strobe. When the phase reaches the active divisor, it emits one output tick and subtracts the divisor. The divisor is a 16-bit unsigned fixed-point ratio: bits 15:11 hold the integer part and bits 10:0 hold the fraction. After reset the divisor is 0x5000, a ratio of exactly 10.000.

Software can write a divisor directly. The block can also calculate one from a measured oscillator period: the period is the number of 12 MHz cycles in 16 oscillator cycles, averaged over several readings. A restoring serial divider computes 384000000 / period, which equals 16 × 12 MHz × 2048 / 1024. The result is a divisor that yields 1024 Hz even when the oscillator is off frequency. A new divisor, from either source, waits in a pending register and replaces the active one only on an output tick, so no output interval is ever cut short.

Top module: `rcdiv_tick_gen`

## Requirements
- R1: After reset, `div_cur` is 0x5000, and `tick_out`, `cal_busy` and `cal_done` are low.
- R2: Each `src_tick` adds 2048 to the phase. If the sum is greater than or equal to the active divisor, `tick_out` is high for exactly the one clock cycle after that strobe and the divisor is subtracted from the phase. With divisor 0x5000, every tenth strobe gives a tick.
- R3: A fractional divisor gives intervals whose average length is divisor/2048 strobes. Starting from zero phase, 0x1C00 (3.5) gives alternating intervals of 4 and 3 strobes.
- R4: A divisor written with `div_wr` does not change `div_cur` or the running interval. It becomes active in the same cycle as the next `tick_out`.
- R5: A candidate divisor whose integer field, bits 15:11, is zero is discarded. The previous active value and any previous pending value are kept.
- R6: A calibration started with `cal_start` produces the divisor 384000000 / `cal_period`, truncated. It is applied at the first tick after `cal_done`. A period of 19200 gives 20000 (0x4E20) and 24000 gives 16000 (0x3E80).
- R7: A calibration quotient above 0xFFFF is clamped to 0xFFFF.
- R8: `cal_busy` is high from the edge that accepts `cal_start` until the division ends. `cal_done` is a one-cycle pulse that appears exactly 32 clock cycles after that edge.
- R9: `cal_start` asserted while `cal_busy` is high has no effect on the running calculation or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | One-cycle strobe per oscillator edge |
| div_wr | input | 1 | Write strobe for a direct divisor |
| div_wdata | input | 16 | Direct divisor, 5.11 fixed point |
| cal_start | input | 1 | Starts the divisor calculation |
| cal_period | input | 24 | Averaged period count for the calculation |
| tick_out | output | 1 | Divided output tick, one cycle wide |
| div_cur | output | 16 | Active divisor |
| cal_busy | output | 1 | Calculation in progress |
| cal_done | output | 1 | Calculation finished, one cycle pulse |

## Verification
The assertions assume that `src_tick` is a single-cycle strobe and that `cal_period` does not change while `cal_busy` is high. They also assume that `div_wr` and `cal_done` never coincide with a tick in a way the checks depend on. The bench spaces every oscillator strobe with an idle cycle between strobes. It changes `cal_period` only together with a `cal_start`, and it writes divisors only between strobes, so a write never lands on a wrap cycle. The second `cal_start`, issued while a calculation is running, carries a different period; only an ignored start could leave the first result intact.

// File: rtl/rcdiv_pkg.sv
package rcdiv_pkg;
   localparam int unsigned DEF_DIV_W   = 16;
   localparam int unsigned DEF_FRAC_W  = 11;
   localparam int unsigned DEF_PER_W   = 24;
   localparam int unsigned DEF_NUM_W   = 32;
   localparam longint unsigned DEF_NUMERATOR = 64'd384000000;

   typedef enum logic {
      SD_IDLE = 1'b0,
      SD_RUN  = 1'b1
   } sd_state_e;
endpackage

// File: rtl/rcdiv_serdiv.sv
module rcdiv_serdiv
   import rcdiv_pkg::*;
#(
   parameter int unsigned     NUM_W     = DEF_NUM_W,
   parameter int unsigned     DEN_W     = DEF_PER_W,
   parameter longint unsigned NUMERATOR = DEF_NUMERATOR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   localparam int unsigned CNT_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);
   localparam logic [NUM_W-1:0] NUM_V = NUM_W'(NUMERATOR);

   sd_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] den_q;
   logic [NUM_W-1:0] q;
   logic             done_q;

   logic [DEN_W:0]   rem_sh;
   logic [DEN_W:0]   rem_diff;
   logic             fits;
   logic [DEN_W-1:0] rem_nx;

   always_comb begin
      rem_sh   = {rem, q[NUM_W-1]};
      rem_diff = rem_sh - {1'b0, den_q};
      fits     = (rem_sh >= {1'b0, den_q});
      rem_nx   = fits ? rem_diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SD_IDLE;
         cnt    <= '0;
         rem    <= '0;
         den_q  <= '0;
         q      <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            SD_IDLE: begin
               if (start) begin
                  state <= SD_RUN;
                  cnt   <= '0;
                  rem   <= '0;
                  den_q <= den;
                  q     <= NUM_V;
               end
            end
            SD_RUN: begin
               rem <= rem_nx;
               q   <= {q[NUM_W-2:0], fits};
               cnt <= cnt + 1'b1;
               if (cnt == LAST) begin
                  state  <= SD_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= SD_IDLE;
         endcase
      end
   end

   assign busy = (state == SD_RUN);
   assign done = done_q;
   assign quo  = q;
endmodule

// File: rtl/rcdiv_divreg.sv
module rcdiv_divreg #(
   parameter int unsigned       DIV_W     = 16,
   parameter int unsigned       FRAC_W    = 11,
   parameter int unsigned       QUO_W     = 32,
   parameter logic [DIV_W-1:0]  RESET_DIV = 16'h5000,
   parameter bit                SATURATE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic [DIV_W-1:0] host_val,
   input  logic             cal_done,
   input  logic [QUO_W-1:0] cal_quo,
   input  logic             commit,
   output logic [DIV_W-1:0] active
);
   localparam int unsigned INT_W = DIV_W - FRAC_W;

   logic             cal_ok;
   logic [DIV_W-1:0] cal_val;
   logic             cand_v;
   logic [DIV_W-1:0] cand;
   logic             cand_ok;
   logic [DIV_W-1:0] pend;
   logic             pend_v;
   logic [DIV_W-1:0] act_q;

   generate
      if (QUO_W <= DIV_W) begin : g_narrow
         assign cal_ok  = 1'b1;
         assign cal_val = DIV_W'(cal_quo);
      end else if (SATURATE) begin : g_clamp
         logic over;
         assign over    = |cal_quo[QUO_W-1:DIV_W];
         assign cal_ok  = 1'b1;
         assign cal_val = over ? {DIV_W{1'b1}} : cal_quo[DIV_W-1:0];
      end else begin : g_drop
         assign cal_ok  = ~|cal_quo[QUO_W-1:DIV_W];
         assign cal_val = cal_quo[DIV_W-1:0];
      end
   endgenerate

   always_comb begin
      cand_v = 1'b0;
      cand   = '0;
      if (host_wr) begin
         cand_v = 1'b1;
         cand   = host_val;
      end else if (cal_done && cal_ok) begin
         cand_v = 1'b1;
         cand   = cal_val;
      end
      cand_ok = |cand[DIV_W-1 -: INT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= RESET_DIV;
         pend   <= RESET_DIV;
         pend_v <= 1'b0;
      end else begin
         if (commit && pend_v) begin
            act_q  <= pend;
            pend_v <= 1'b0;
         end
         if (cand_v && cand_ok) begin
            pend   <= cand;
            pend_v <= 1'b1;
         end
      end
   end

   assign active = act_q;
endmodule

// File: rtl/rcdiv_phase.sv
module rcdiv_phase #(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned FRAC_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic [DIV_W-1:0] divisor,
   output logic             wrap,
   output logic             tick
);
   localparam int unsigned PH_W = DIV_W + 1;
   localparam logic [PH_W-1:0] STEP = PH_W'(1) << FRAC_W;

   logic [PH_W-1:0] phase;
   logic [PH_W-1:0] sum;
   logic [PH_W-1:0] div_x;
   logic            tick_q;

   always_comb begin
      div_x = {1'b0, divisor};
      sum   = phase + STEP;
      wrap  = src_tick && (sum >= div_x);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= wrap;
         if (src_tick) begin
            phase <= wrap ? (sum - div_x) : sum;
         end
      end
   end

   assign tick = tick_q;
endmodule

// File: rtl/rcdiv_tick_gen.sv
module rcdiv_tick_gen
   import rcdiv_pkg::*;
#(
   parameter int unsigned     DIV_W     = DEF_DIV_W,
   parameter int unsigned     FRAC_W    = DEF_FRAC_W,
   parameter int unsigned     PER_W     = DEF_PER_W,
   parameter int unsigned     NUM_W     = DEF_NUM_W,
   parameter longint unsigned NUMERATOR = DEF_NUMERATOR,
   parameter logic [DIV_W-1:0] RESET_DIV = 16'h5000,
   parameter bit              SATURATE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_wdata,
   input  logic             cal_start,
   input  logic [PER_W-1:0] cal_period,
   output logic             tick_out,
   output logic [DIV_W-1:0] div_cur,
   output logic             cal_busy,
   output logic             cal_done
);
   generate
      if (FRAC_W == 0 || FRAC_W >= DIV_W) begin : g_bad_frac
         $error("rcdiv_tick_gen: FRAC_W must lie between 1 and DIV_W-1");
      end
      if (NUM_W < 2 || NUM_W > 64) begin : g_bad_num
         $error("rcdiv_tick_gen: NUM_W must lie between 2 and 64");
      end
      if (RESET_DIV[DIV_W-1 -: (DIV_W - FRAC_W)] == '0) begin : g_bad_rst
         $error("rcdiv_tick_gen: RESET_DIV needs a nonzero integer part");
      end
   endgenerate

   logic             wrap;
   logic [NUM_W-1:0] quo;
   logic [DIV_W-1:0] active;

   rcdiv_serdiv #(
      .NUM_W     (NUM_W),
      .DEN_W     (PER_W),
      .NUMERATOR (NUMERATOR)
   ) u_serdiv (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cal_start),
      .den   (cal_period),
      .busy  (cal_busy),
      .done  (cal_done),
      .quo   (quo)
   );

   rcdiv_divreg #(
      .DIV_W     (DIV_W),
      .FRAC_W    (FRAC_W),
      .QUO_W     (NUM_W),
      .RESET_DIV (RESET_DIV),
      .SATURATE  (SATURATE)
   ) u_divreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_wr  (div_wr),
      .host_val (div_wdata),
      .cal_done (cal_done),
      .cal_quo  (quo),
      .commit   (wrap),
      .active   (active)
   );

   rcdiv_phase #(
      .DIV_W  (DIV_W),
      .FRAC_W (FRAC_W)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .divisor  (active),
      .wrap     (wrap),
      .tick     (tick_out)
   );

   assign div_cur = active;
endmodule

// File: rtl/rcdiv_tick_gen_chk.sv
module rcdiv_tick_gen_chk #(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned FRAC_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             src_tick,
   input logic             tick_out,
   input logic [DIV_W-1:0] div_cur,
   input logic             cal_busy,
   input logic             cal_done
);
   p_tick_after_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_out |-> $past(src_tick));

   p_div_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_cur) |-> tick_out);

   p_div_int_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      div_cur[DIV_W-1 -: (DIV_W - FRAC_W)] != '0);

   p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cal_busy) |-> cal_done);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done);

   p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> !cal_busy);
endmodule

bind rcdiv_tick_gen rcdiv_tick_gen_chk #(
   .DIV_W  (DIV_W),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_tick (src_tick),
   .tick_out (tick_out),
   .div_cur  (div_cur),
   .cal_busy (cal_busy),
   .cal_done (cal_done)
);

// File: tb/rcdiv_tick_gen_bench.sv
`timescale 1ns/1ps
module rcdiv_tick_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_tick = 1'b0;
   logic        div_wr = 1'b0;
   logic [15:0] div_wdata = '0;
   logic        cal_start = 1'b0;
   logic [23:0] cal_period = '0;
   logic        tick_out;
   logic [15:0] div_cur;
   logic        cal_busy;
   logic        cal_done;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   rcdiv_tick_gen u_rcdiv_tick_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_tick   (src_tick),
      .div_wr     (div_wr),
      .div_wdata  (div_wdata),
      .cal_start  (cal_start),
      .cal_period (cal_period),
      .tick_out   (tick_out),
      .div_cur    (div_cur),
      .cal_busy   (cal_busy),
      .cal_done   (cal_done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      src_tick = 1'b0; div_wr = 1'b0; cal_start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic edge_pulse(output logic t);
      src_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      src_tick = 1'b0;
      t = tick_out;
      @(posedge clk); @(negedge clk);
   endtask

   // feeds n strobes, returns bitmask of strobe positions (1-based) that ticked
   task automatic run_edges(input int n, output logic [63:0] mask);
      logic t;
      mask = '0;
      for (int i = 1; i <= n; i++) begin
         edge_pulse(t);
         if (t) mask[i] = 1'b1;
      end
   endtask

   task automatic write_div(input logic [15:0] v);
      div_wdata = v; div_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      div_wr = 1'b0;
   endtask

   // start calibration, return cycles until cal_done (edge accepting start = 0)
   task automatic calibrate(input logic [23:0] per, output int lat);
      cal_period = per; cal_start = 1'b1;
      @(posedge clk); @(negedge clk);
      cal_start = 1'b0;
      lat = 0;
      for (int k = 1; k <= 100; k++) begin
         @(posedge clk); @(negedge clk);
         if (cal_done) begin lat = k; break; end
      end
   endtask

   task automatic run_until_tick();
      logic t;
      for (int i = 0; i < 80; i++) begin
         edge_pulse(t);
         if (t) break;
      end
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 div_cur", 32'(div_cur), 32'h5000);
      check("R1 tick_out", 32'(tick_out), 0);
      check("R1 cal_busy", 32'(cal_busy), 0);
      check("R1 cal_done", 32'(cal_done), 0);
   endtask

   task automatic t_ratio10();
      logic [63:0] m;
      logic [63:0] e;
      do_reset();
      run_edges(30, m);
      e = '0; e[10] = 1; e[20] = 1; e[30] = 1;
      check("R2 ticks every 10 strobes", m[31:0], e[31:0]);
   endtask

   task automatic t_fraction();
      logic [63:0] m;
      logic [63:0] e;
      do_reset();
      write_div(16'h1C00);
      run_edges(10, m);
      check("R3 commit divisor", 32'(div_cur), 32'h1C00);
      run_edges(14, m);
      e = '0; e[4] = 1; e[7] = 1; e[11] = 1; e[14] = 1;
      check("R3 intervals 4,3,4,3", m[31:0], e[31:0]);
   endtask

   task automatic t_commit();
      logic [63:0] m;
      logic [63:0] e;
      do_reset();
      run_edges(3, m);
      write_div(16'h2000);
      check("R4 pending not active", 32'(div_cur), 32'h5000);
      run_edges(7, m);
      e = '0; e[7] = 1;
      check("R4 running interval kept", m[31:0], e[31:0]);
      check("R4 committed at tick", 32'(div_cur), 32'h2000);
      run_edges(8, m);
      e = '0; e[4] = 1; e[8] = 1;
      check("R4 new ratio 4", m[31:0], e[31:0]);
   endtask

   task automatic t_reject();
      logic [63:0] m;
      logic [63:0] e;
      do_reset();
      write_div(16'h2800);
      write_div(16'h07FF);
      run_edges(20, m);
      e = '0; e[10] = 1; e[15] = 1; e[20] = 1;
      check("R5 zero integer discarded, pending kept", m[31:0], e[31:0]);
      check("R5 div_cur", 32'(div_cur), 32'h2800);
   endtask

   task automatic t_cal_basic();
      int lat;
      do_reset();
      calibrate(24'd19200, lat);
      check("R8 done latency", 32'(lat), 32'd32);
      @(posedge clk); @(negedge clk);
      check("R8 done single cycle", 32'(cal_done), 0);
      check("R6 not yet active", 32'(div_cur), 32'h5000);
      run_until_tick();
      check("R6 quotient 19200", 32'(div_cur), 32'd20000);
   endtask

   task automatic t_cal_sat();
      int lat;
      do_reset();
      calibrate(24'd5000, lat);
      run_until_tick();
      check("R7 clamp", 32'(div_cur), 32'hFFFF);
      calibrate(24'd200000, lat);
      run_until_tick();
      run_until_tick();
      check("R5 small quotient discarded", 32'(div_cur), 32'hFFFF);
   endtask

   task automatic t_cal_busy();
      int lat;
      do_reset();
      cal_period = 24'd24000; cal_start = 1'b1;
      @(posedge clk); @(negedge clk);
      cal_start = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R8 busy while running", 32'(cal_busy), 1);
      cal_period = 24'd19200; cal_start = 1'b1;
      @(posedge clk); @(negedge clk);
      cal_start = 1'b0;
      lat = 0;
      for (int k = 1; k <= 100; k++) begin
         @(posedge clk); @(negedge clk);
         if (cal_done) begin lat = k; break; end
      end
      check("R9 done timing unchanged", 32'(lat), 32'd27);
      run_until_tick();
      check("R9 result of first start", 32'(div_cur), 32'd16000);
   endtask

   initial begin
      t_reset();
      t_ratio10();
      t_fraction();
      t_commit();
      t_reject();
      t_cal_basic();
      t_cal_sat();
      t_cal_busy();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule